// File: doc/BRIEF.md
# Two-Key Register Write Gate

This block sits between a bus master and a peripheral's register file. It stops accidental or stray software writes from reaching the protected registers. Each write arrives as an address, a 32-bit data word and a strobe. The gate decides in the same cycle whether the strobe goes on to the register file. Two addresses are reserved as key registers. The gate opens only after the first key register receives its exact 32-bit key and the second key register then receives its own exact key. Writing any other value to either key register, zero included, closes the gate again.

The lock logic is a three-state machine:

- `GATE_LOCKED` is the reset state and rejects protected writes.
- `GATE_ARMED` is entered when the first key arrives. It still rejects protected writes.
- `GATE_OPEN` forwards protected writes.

The transitions are named as follows:

- `arm` takes LOCKED to ARMED when a correct first key is written.
- `open` takes ARMED to OPEN when a correct second key is written.
- `rearm` keeps ARMED when a correct first key is written again.
- `abort` takes ARMED to LOCKED when a wrong key value is written to either key register.
- `relock` takes OPEN to LOCKED when a wrong key value is written to either key register.
- `hold` covers every other case, with no state change.

Reads are never blocked. A read of a key address returns zero, and any other read returns the register file's data unchanged. Writes to addresses above the protected window pass through whatever the lock state. Writes to the key registers never reach the register file.

Top module: `wgate_top`

## Requirements
- R1: After reset, and after any reset applied while open, `locked` is 1 and protected writes are suppressed.
- R2: The gate opens only through the following sequence:
  - write 0x83E70B13 to address 0x6C;
  - then write 0x95A4F1E0 to address 0x70;
  - `locked` reads 0 from the cycle after the second write.
- R3: A correct second key written while the gate is locked and not armed leaves it locked.
- R4: Writing any value other than its key (zero included) to address 0x6C or 0x70 makes `locked` 1 from the next cycle, from either the armed or the open state.
- R5: While locked or armed, a write to the protected window 0x00..0x6B (boundary 0x68 included) does not assert `reg_wr_en`.
- R6: While open, a write to the protected window asserts `reg_wr_en` in the same cycle, with address and data unchanged.
- R7: A write to an address above 0x73 asserts `reg_wr_en` in every lock state.
- R8: A write to either key address never asserts `reg_wr_en`.
- R9: A read of address 0x6C or 0x70 returns zero in any lock state. Any other read returns `reg_rd_data` unchanged.
- R10: Writes to non-key addresses, and repeated correct first keys, between the two keys do not break the unlock sequence.
- R11: While open, rewriting the correct key to either key register keeps the gate open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe from the bus |
| bus_wr_addr | input | 8 | Write byte address |
| bus_wr_data | input | 32 | Write data |
| bus_rd_addr | input | 8 | Read byte address |
| bus_rd_data | output | 32 | Read data returned to the bus |
| reg_wr_en | output | 1 | Gated write strobe to the register file |
| reg_wr_addr | output | 8 | Write address to the register file |
| reg_wr_data | output | 32 | Write data to the register file |
| reg_rd_addr | output | 8 | Read address to the register file |
| reg_rd_data | input | 32 | Read data from the register file |
| locked | output | 1 | 1 unless the gate is open |

## Verification
The hardest case to reach is the armed state, because it is visible at the ports only as a locked gate that one more write will open. The stimulus table reaches it on purpose, in three ways:

- it interleaves unrelated writes and a repeated first key between the two keys;
- it aborts the armed state with a wrong first key;
- it follows an abort with a lone second key, which must not open the gate.

A bench-side register array records every forwarded write. Later reads through the gate then show which blocked writes never landed, including writes at the window's boundary word.

// File: rtl/wgate_pkg.sv
package wgate_pkg;
    typedef enum logic [1:0] {
        GATE_LOCKED = 2'd0,
        GATE_ARMED  = 2'd1,
        GATE_OPEN   = 2'd2
    } gate_state_e;
endpackage

// File: rtl/wgate_decode.sv
// Classifies one address: first key, second key, or protected window.
module wgate_decode #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] KEY0_ADDR = 8'h6C,
    parameter logic [ADDR_W-1:0] KEY1_ADDR = 8'h70,
    parameter logic [ADDR_W-1:0] PROT_LO   = 8'h00,
    parameter logic [ADDR_W-1:0] PROT_HI   = 8'h6B
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_key0,
    output logic              hit_key1,
    output logic              hit_prot
);
    localparam logic [ADDR_W-1:0] SPAN = PROT_HI - PROT_LO;

    logic [ADDR_W-1:0] offs;

    always_comb begin
        offs     = addr - PROT_LO;
        hit_key0 = (addr == KEY0_ADDR);
        hit_key1 = (addr == KEY1_ADDR);
        hit_prot = (offs <= SPAN);
    end
endmodule

// File: rtl/wgate_fsm.sv
// Lock state machine: LOCKED -arm-> ARMED -open-> OPEN; abort/relock back to LOCKED.
module wgate_fsm
    import wgate_pkg::*;
#(
    parameter logic [31:0] KEY0_VAL = 32'h83E70B13,
    parameter logic [31:0] KEY1_VAL = 32'h95A4F1E0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        hit_key0,
    input  logic        hit_key1,
    input  logic [31:0] wr_data,
    output gate_state_e state,
    output logic        locked
);
    gate_state_e nxt;
    logic        k0_ok, k1_ok, k0_bad, k1_bad;

    always_comb begin
        k0_ok  = wr_en && hit_key0 && (wr_data == KEY0_VAL);
        k1_ok  = wr_en && hit_key1 && (wr_data == KEY1_VAL);
        k0_bad = wr_en && hit_key0 && (wr_data != KEY0_VAL);
        k1_bad = wr_en && hit_key1 && (wr_data != KEY1_VAL);
        nxt    = state;
        unique case (state)
            GATE_LOCKED: begin
                if (k0_ok) nxt = GATE_ARMED;              // arm
            end
            GATE_ARMED: begin
                if (k0_bad || k1_bad) nxt = GATE_LOCKED;  // abort
                else if (k1_ok)       nxt = GATE_OPEN;    // open
                else                  nxt = GATE_ARMED;   // rearm / hold
            end
            GATE_OPEN: begin
                if (k0_bad || k1_bad) nxt = GATE_LOCKED;  // relock
            end
            default: nxt = GATE_LOCKED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= GATE_LOCKED;
        else        state <= nxt;
    end

    // outputs
    always_comb begin
        locked = (state != GATE_OPEN);
    end
endmodule

// File: rtl/wgate_path.sv
// Write-strobe gating and read-data masking.
module wgate_path (
    input  logic        wr_en,
    input  logic        wr_key,
    input  logic        wr_prot,
    input  logic        open,
    input  logic        rd_key,
    input  logic [31:0] rd_in,
    output logic        wr_out,
    output logic [31:0] rd_out
);
    always_comb begin
        wr_out = wr_en && !wr_key && (!wr_prot || open);
        rd_out = rd_key ? 32'h0 : rd_in;
    end
endmodule

// File: rtl/wgate_top.sv
module wgate_top
    import wgate_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] KEY0_ADDR = 8'h6C,
    parameter logic [ADDR_W-1:0] KEY1_ADDR = 8'h70,
    parameter logic [ADDR_W-1:0] PROT_LO   = 8'h00,
    parameter logic [ADDR_W-1:0] PROT_HI   = 8'h6B,
    parameter logic [31:0]       KEY0_VAL  = 32'h83E70B13,
    parameter logic [31:0]       KEY1_VAL  = 32'h95A4F1E0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_wr_addr,
    input  logic [31:0]       bus_wr_data,
    input  logic [ADDR_W-1:0] bus_rd_addr,
    output logic [31:0]       bus_rd_data,
    output logic              reg_wr_en,
    output logic [ADDR_W-1:0] reg_wr_addr,
    output logic [31:0]       reg_wr_data,
    output logic [ADDR_W-1:0] reg_rd_addr,
    input  logic [31:0]       reg_rd_data,
    output logic              locked
);
    localparam int NPORT = 2;  // 0 = write side, 1 = read side

    logic [NPORT-1:0] k0, k1, prot;
    logic [ADDR_W-1:0] dec_addr [NPORT];
    gate_state_e state;

    assign dec_addr[0] = bus_wr_addr;
    assign dec_addr[1] = bus_rd_addr;

    for (genvar g = 0; g < NPORT; g++) begin : g_dec
        wgate_decode #(
            .ADDR_W(ADDR_W), .KEY0_ADDR(KEY0_ADDR), .KEY1_ADDR(KEY1_ADDR),
            .PROT_LO(PROT_LO), .PROT_HI(PROT_HI)
        ) u_dec (
            .addr(dec_addr[g]), .hit_key0(k0[g]), .hit_key1(k1[g]), .hit_prot(prot[g])
        );
    end

    wgate_fsm #(.KEY0_VAL(KEY0_VAL), .KEY1_VAL(KEY1_VAL)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en),
        .hit_key0(k0[0]), .hit_key1(k1[0]), .wr_data(bus_wr_data),
        .state(state), .locked(locked)
    );

    wgate_path u_path (
        .wr_en(bus_wr_en), .wr_key(k0[0] | k1[0]), .wr_prot(prot[0]),
        .open(state == GATE_OPEN), .rd_key(k0[1] | k1[1]),
        .rd_in(reg_rd_data), .wr_out(reg_wr_en), .rd_out(bus_rd_data)
    );

    assign reg_wr_addr = bus_wr_addr;
    assign reg_wr_data = bus_wr_data;
    assign reg_rd_addr = bus_rd_addr;

    wire unused_prot_rd = prot[1];
endmodule

// File: rtl/wgate_chk.sv
module wgate_chk #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] KEY0_ADDR = 8'h6C,
    parameter logic [ADDR_W-1:0] KEY1_ADDR = 8'h70,
    parameter logic [ADDR_W-1:0] PROT_LO   = 8'h00,
    parameter logic [ADDR_W-1:0] PROT_HI   = 8'h6B,
    parameter logic [31:0]       KEY0_VAL  = 32'h83E70B13,
    parameter logic [31:0]       KEY1_VAL  = 32'h95A4F1E0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_en,
    input logic [ADDR_W-1:0] bus_wr_addr,
    input logic [31:0]       bus_wr_data,
    input logic [ADDR_W-1:0] bus_rd_addr,
    input logic [31:0]       bus_rd_data,
    input logic              reg_wr_en,
    input logic              locked
);
    logic wkey, rkey, wprot, wbad;
    logic [ADDR_W-1:0] woffs;

    always_comb begin
        wkey  = (bus_wr_addr == KEY0_ADDR) || (bus_wr_addr == KEY1_ADDR);
        rkey  = (bus_rd_addr == KEY0_ADDR) || (bus_rd_addr == KEY1_ADDR);
        woffs = bus_wr_addr - PROT_LO;
        wprot = (woffs <= (PROT_HI - PROT_LO));
        wbad  = bus_wr_en && (((bus_wr_addr == KEY0_ADDR) && (bus_wr_data != KEY0_VAL)) ||
                              ((bus_wr_addr == KEY1_ADDR) && (bus_wr_data != KEY1_VAL)));
    end

    a_r2_open_after_key1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(bus_wr_en && bus_wr_addr == KEY1_ADDR && bus_wr_data == KEY1_VAL));

    a_r4_bad_key_relocks: assert property (@(posedge clk) disable iff (!rst_n)
        wbad |=> locked);

    a_r5_locked_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && bus_wr_en && wprot) |-> !reg_wr_en);

    a_r7_outside_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && !wprot && !wkey) |-> reg_wr_en);

    a_r8_key_never_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && wkey) |-> !reg_wr_en);

    a_r9_key_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rkey |-> (bus_rd_data == 32'h0));
endmodule

bind wgate_top wgate_chk #(
    .ADDR_W(ADDR_W), .KEY0_ADDR(KEY0_ADDR), .KEY1_ADDR(KEY1_ADDR),
    .PROT_LO(PROT_LO), .PROT_HI(PROT_HI), .KEY0_VAL(KEY0_VAL), .KEY1_VAL(KEY1_VAL)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_wr_addr(bus_wr_addr),
    .bus_wr_data(bus_wr_data), .bus_rd_addr(bus_rd_addr), .bus_rd_data(bus_rd_data),
    .reg_wr_en(reg_wr_en), .locked(locked)
);

// File: tb/tb_wgate_top.sv
module tb_wgate_top;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] K0 = 32'h83E70B13;
    localparam logic [31:0] K1 = 32'h95A4F1E0;
    localparam int          NV = 22;

    // {write, addr[7:0], data[31:0], expect forward, expect locked after}
    localparam logic [42:0] VEC [NV] = '{
        {1'b1, 8'h04, 32'h0000_0011, 1'b0, 1'b1},  // 0  R5 locked blocks
        {1'b1, 8'h70, K1,            1'b0, 1'b1},  // 1  R3 key1 alone
        {1'b1, 8'h6C, K0,            1'b0, 1'b1},  // 2  R10 armed
        {1'b1, 8'h74, 32'h0000_0055, 1'b1, 1'b1},  // 3  R7 outside window
        {1'b1, 8'h08, 32'h0000_0022, 1'b0, 1'b1},  // 4  R5 armed blocks
        {1'b1, 8'h70, K1,            1'b0, 1'b0},  // 5  R2 open
        {1'b1, 8'h08, 32'h0000_0033, 1'b1, 1'b0},  // 6  R6 forwarded
        {1'b1, 8'h68, 32'h0000_0066, 1'b1, 1'b0},  // 7  R6 boundary word
        {1'b1, 8'h6C, K0,            1'b0, 1'b0},  // 8  R11 rewrite key
        {1'b1, 8'h70, 32'h0,         1'b0, 1'b1},  // 9  R4 zero relocks
        {1'b1, 8'h68, 32'h0000_0099, 1'b0, 1'b1},  // 10 R5 boundary blocked
        {1'b1, 8'h6C, K0,            1'b0, 1'b1},  // 11 R10
        {1'b1, 8'h6C, K0,            1'b0, 1'b1},  // 12 R10 repeat key0
        {1'b1, 8'h70, 32'h95A4_F1E1, 1'b0, 1'b1},  // 13 R4 wrong key1
        {1'b1, 8'h6C, K0,            1'b0, 1'b1},  // 14 R10
        {1'b1, 8'h6C, 32'h0,         1'b0, 1'b1},  // 15 R4 wrong key0 aborts
        {1'b1, 8'h70, K1,            1'b0, 1'b1},  // 16 R3 after abort
        {1'b1, 8'h6C, K0,            1'b0, 1'b1},  // 17 R10
        {1'b1, 8'h70, K1,            1'b0, 1'b0},  // 18 R2
        {1'b1, 8'h6C, 32'h1234_5678, 1'b0, 1'b1},  // 19 R4 relock from open
        {1'b0, 8'h08, 32'h0000_ABCD, 1'b0, 1'b1},  // 20 R5 idle
        {1'b1, 8'h70, K1,            1'b0, 1'b1}   // 21 R8 key not forwarded
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [7:0]  bus_wr_addr = '0;
    logic [31:0] bus_wr_data = '0;
    logic [7:0]  bus_rd_addr = '0;
    logic [31:0] bus_rd_data;
    logic        reg_wr_en;
    logic [7:0]  reg_wr_addr;
    logic [31:0] reg_wr_data;
    logic [7:0]  reg_rd_addr;
    logic [31:0] reg_rd_data;
    logic        locked;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] rf [64];
    logic [63:0] written;

    always #(CLK_PERIOD/2) clk = ~clk;

    wgate_top dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_wr_addr(bus_wr_addr),
        .bus_wr_data(bus_wr_data), .bus_rd_addr(bus_rd_addr), .bus_rd_data(bus_rd_data),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data), .locked(locked)
    );

    // Protected register file model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) written <= '0;
        else if (reg_wr_en) begin
            rf[reg_wr_addr[7:2]]      <= reg_wr_data;
            written[reg_wr_addr[7:2]] <= 1'b1;
        end
    end
    assign reg_rd_data = written[reg_rd_addr[7:2]] ? rf[reg_rd_addr[7:2]]
                                                   : (32'hA500_0000 | 32'(reg_rd_addr[7:2]));

    function automatic string vtag(int i);
        case (i)
            0, 4, 10, 20:              return "R5";
            1, 16:                     return "R3";
            2, 11, 12, 14, 17:         return "R10";
            3:                         return "R7";
            5, 18:                     return "R2";
            6, 7:                      return "R6";
            8:                         return "R11";
            9, 13, 15, 19:             return "R4";
            default:                   return "R8";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_rd_addr = a;
        #1;
        check(tag, bus_rd_data, exp);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_wr_addr = a; bus_wr_data = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 locked during reset", 32'(locked), 32'd1);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 locked after reset", 32'(locked), 32'd1);
        bus_wr_en = 1'b1; bus_wr_addr = 8'h00; bus_wr_data = 32'h77;
        #1;
        check("R1 write blocked after reset", 32'(reg_wr_en), 32'd0);
        @(negedge clk);
        bus_wr_en = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_wr_en   = VEC[i][42];
            bus_wr_addr = VEC[i][41:34];
            bus_wr_data = VEC[i][33:2];
            #1;
            check({vtag(i), " strobe"}, 32'(reg_wr_en), 32'(VEC[i][1]));
            if (VEC[i][1]) begin
                check({vtag(i), " addr"}, 32'(reg_wr_addr), 32'(VEC[i][41:34]));
                check({vtag(i), " data"}, reg_wr_data, VEC[i][33:2]);
            end
            @(posedge clk);
            #1;
            check({vtag(i), " locked"}, 32'(locked), 32'(VEC[i][0]));
        end
        @(negedge clk);
        bus_wr_en = 1'b0;

        // Read-back through the gate
        rd(8'h6C, 32'h0, "R9 key0 read locked");
        rd(8'h70, 32'h0, "R9 key1 read locked");
        rd(8'h08, 32'h33, "R6 stored open write");
        rd(8'h68, 32'h66, "R5 blocked boundary write absent");
        rd(8'h04, 32'hA500_0001, "R5 blocked write absent");
        rd(8'h00, 32'hA500_0000, "R1 post-reset write absent");
        rd(8'h74, 32'h55, "R7 outside write stored");

        // Open, then reset while open
        wr(8'h6C, K0);
        wr(8'h70, K1);
        #1;
        check("R2 open before reset", 32'(locked), 32'd0);
        rd(8'h70, 32'h0, "R9 key1 read open");
        rd(8'h1C, 32'hA500_0007, "R9 plain read open");
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 reset while open", 32'(locked), 32'd1);
        @(negedge clk);
        rst_n = 1'b1;
        bus_wr_en = 1'b1; bus_wr_addr = 8'h10; bus_wr_data = 32'h5A;
        #1;
        check("R1 write blocked after reset while open", 32'(reg_wr_en), 32'd0);
        @(negedge clk);
        bus_wr_en = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule